// File: doc/BRIEF.md
# Dithered phase-truncating NCO core

This block is the digital core of a direct synthesis oscillator. A 32-bit phase accumulator grows by a frequency tuning word on every clock once the core has started. Its value wraps modulo 2^32, so the output frequency is the tuning word times the clock frequency divided by 2^32. A programmable phase offset is added to the accumulator value. Optionally, a pseudo-random dither term is added to the bits that are about to be discarded. The sum is then cut down to a 12-bit phase. That phase addresses a quarter-wave magnitude table; mirroring and negation extend the table to a full cycle. The core delivers a sine and a cosine sample as 14-bit two's-complement values, together with a valid flag.

Software loads a staged tuning word and a staged offset through a small write port. A commit write copies both to the working registers on the same clock edge. The accumulator is never cleared by a commit, so frequency changes are phase-continuous.

A three-state controller sequences start-up:
- **ST_IDLE** is the state after reset. The accumulator is held at zero and the outputs read zero.
- **IDLE_TO_FILL** is taken on the first commit.
- **ST_FILL** counts the three pipeline stages; **FILL_STAY** repeats while that count is short.
- **FILL_TO_RUN** is taken once the pipeline holds real data.
- **ST_RUN** raises the valid flag; **RUN_STAY** keeps the core there until reset.

Top module: `nco_dither_core`

## Requirements
- R1: Once running, the accumulator adds the working tuning word on every clock and wraps modulo 2^32. Output phase p is bits [31:20] of (accumulator + offset) mod 2^32 when dither is off.
- R2: A tuning-word write (wr_addr 0) of a value above 2^31 stages exactly 2^31. Values up to 2^31 are staged unchanged.
- R3: Writes to wr_addr 0 (tuning word) and wr_addr 1 (offset) only stage values and leave the output unchanged. A write to wr_addr 2 (commit, data ignored) moves both staged values into use on the same edge.
- R4: A commit never resets the accumulator. The next accumulator value is the previous value plus the newly committed tuning word.
- R5: The working offset is added to the accumulator before truncation, shifting the output phase by offset/2^32 of a cycle.
- R6: sin_out equals round(8191·sin(2π(p+0.5)/4096)) and cos_out equals the same function at p+1024, within ±1 LSB. Both are 14-bit two's complement and never -8192.
- R7: With dither_en high, a 16-bit maximal-length LFSR value shifted left by 4 is added below bit 20 before truncation, so the phase used is p or p+1. With dither_en low, no dither is added.
- R8: The sample for the accumulator value present before clock edge k appears after edge k+2 (3-cycle latency). out_valid rises exactly 3 clocks after the edge that takes the first commit.
- R9: After reset the core is in ST_IDLE: out_valid is 0, both samples read 0, and the accumulator stays at 0 until the first commit. Once out_valid is 1 it stays 1 until reset.
- R10: A write to wr_addr 3 changes neither the staged nor the working values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | 0 tuning word, 1 offset, 2 commit, 3 unused |
| wr_data | input | 32 | Write data |
| dither_en | input | 1 | Enables phase dither |
| sin_out | output | 14 | Sine sample, two's complement, zero while not valid |
| cos_out | output | 14 | Cosine sample, two's complement, zero while not valid |
| out_valid | output | 1 | Samples carry real data |

## Verification
The assertions assume that wr_addr is stable and meaningful whenever wr_en is high, and that a commit is never issued in the same cycle as a staging write, since both share one port. The stimulus drives one write per cycle, always as a one-cycle strobe away from the clock edge. Reset is held for several edges before any write, and rst_n is low from time zero, so the reset-qualified properties never see pre-reset state. Dither runs only in a separate section after a fresh reset, where the expected phase is a set of two values rather than one.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int NCO_ACC_W    = 32;
    localparam int NCO_PH_W     = 12;
    localparam int NCO_AMP_W    = 14;
    localparam int NCO_LFSR_W   = 16;
    localparam int NCO_PIPE_LAT = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } nco_state_e;

    typedef enum logic [1:0] {
        SEL_FTW    = 2'd0,
        SEL_OFF    = 2'd1,
        SEL_COMMIT = 2'd2,
        SEL_SPARE  = 2'd3
    } nco_sel_e;
endpackage

// File: rtl/nco_regs.sv
module nco_regs
    import nco_pkg::*;
#(
    parameter int ACC_W = NCO_ACC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    output logic             commit,
    output logic [ACC_W-1:0] act_ftw,
    output logic [ACC_W-1:0] act_off
);
    localparam logic [ACC_W-1:0] FTW_LIM = {1'b1, {(ACC_W-1){1'b0}}};

    nco_sel_e         sel;
    logic             ld_ftw;
    logic             ld_off;
    logic [ACC_W-1:0] clamped;
    logic [ACC_W-1:0] stg_ftw;
    logic [ACC_W-1:0] stg_off;

    assign sel     = nco_sel_e'(wr_addr);
    assign clamped = (wr_data > FTW_LIM) ? FTW_LIM : wr_data;

    always_comb begin
        ld_ftw = 1'b0;
        ld_off = 1'b0;
        commit = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_FTW:    ld_ftw = 1'b1;
                SEL_OFF:    ld_off = 1'b1;
                SEL_COMMIT: commit = 1'b1;
                SEL_SPARE:  ;
                default:    ;
            endcase
        end
    end

    // staging side
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_ftw <= '0;
            stg_off <= '0;
        end else begin
            if (ld_ftw) stg_ftw <= clamped;
            if (ld_off) stg_off <= wr_data;
        end
    end

    // working side, both words move on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_ftw <= '0;
            act_off <= '0;
        end else if (commit) begin
            act_ftw <= stg_ftw;
            act_off <= stg_off;
        end
    end
endmodule

// File: rtl/nco_ctrl.sv
module nco_ctrl
    import nco_pkg::*;
#(
    parameter int LAT = NCO_PIPE_LAT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit,
    output nco_state_e state,
    output logic       run_en,
    output logic       out_valid
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] LAST = CW'(LAT - 1);

    nco_state_e st_q;
    nco_state_e st_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (commit) begin
                    st_d  = ST_FILL;
                    cnt_d = '0;
                end
            end
            ST_FILL: begin
                if (cnt_q == LAST) st_d = ST_RUN;
                else               cnt_d = cnt_q + 1'b1;
            end
            ST_RUN:  st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state     = st_q;
        run_en    = (st_q != ST_IDLE);
        out_valid = (st_q == ST_RUN);
    end
endmodule

// File: rtl/nco_phase.sv
module nco_phase
    import nco_pkg::*;
#(
    parameter int                ACC_W     = NCO_ACC_W,
    parameter int                PH_W      = NCO_PH_W,
    parameter int                LFSR_W    = NCO_LFSR_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             dither_en,
    input  logic [ACC_W-1:0] act_ftw,
    input  logic [ACC_W-1:0] act_off,
    output logic [ACC_W-1:0] acc_q,
    output logic [PH_W-1:0]  phase_q
);
    localparam int DROP = ACC_W - PH_W;
    localparam int DSH  = DROP - LFSR_W;

    logic [LFSR_W-1:0] lfsr_q;
    logic [ACC_W-1:0]  dither;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc_q <= '0;
        else if (run_en) acc_q <= acc_q + act_ftw;
    end

    // Galois LFSR, right shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         lfsr_q <= LFSR_SEED;
        else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ LFSR_TAPS;
        else                lfsr_q <= lfsr_q >> 1;
    end

    assign dither = dither_en ? (ACC_W'(lfsr_q) << DSH) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= PH_W'((acc_q + act_off + dither) >> DROP);
    end
endmodule

// File: rtl/nco_lut.sv
module nco_lut
    import nco_pkg::*;
#(
    parameter int PH_W  = NCO_PH_W,
    parameter int AMP_W = NCO_AMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase,
    output logic [AMP_W-1:0] sin_q,
    output logic [AMP_W-1:0] cos_q
);
    localparam int  QA_W    = PH_W - 2;
    localparam int  DEPTH   = 1 << QA_W;
    localparam int  MAG_W   = AMP_W - 1;
    localparam real FULL    = real'((1 << (AMP_W - 1)) - 1);
    localparam real HALF_PI = 1.5707963267948966;

    logic [MAG_W-1:0] rom [DEPTH];
    logic [AMP_W-1:0] amp [2];

    // quarter wave sampled at half-step points so mirroring is exact
    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            rom[i] = MAG_W'($rtoi(FULL * $sin(HALF_PI * (real'(i) + 0.5) / real'(DEPTH)) + 0.5));
        end
    end

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        localparam logic [PH_W-1:0] SHIFT = (ch == 0) ? '0 : PH_W'(DEPTH);

        logic [PH_W-1:0]  p;
        logic [QA_W-1:0]  addr;
        logic [MAG_W-1:0] mag_q;
        logic             neg_q;
        logic [AMP_W-1:0] amp_q;

        assign p    = phase + SHIFT;
        assign addr = p[PH_W-2] ? ~p[QA_W-1:0] : p[QA_W-1:0];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mag_q <= '0;
                neg_q <= 1'b0;
            end else begin
                mag_q <= rom[addr];
                neg_q <= p[PH_W-1];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     amp_q <= '0;
            else if (neg_q) amp_q <= AMP_W'(-$signed({1'b0, mag_q}));
            else            amp_q <= AMP_W'($signed({1'b0, mag_q}));
        end

        assign amp[ch] = amp_q;
    end

    assign sin_q = amp[0];
    assign cos_q = amp[1];
endmodule

// File: rtl/nco_dither_core.sv
module nco_dither_core
    import nco_pkg::*;
#(
    parameter int                ACC_W     = NCO_ACC_W,
    parameter int                PH_W      = NCO_PH_W,
    parameter int                AMP_W     = NCO_AMP_W,
    parameter int                LFSR_W    = NCO_LFSR_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [ACC_W-1:0] wr_data,
    input  logic             dither_en,
    output logic [AMP_W-1:0] sin_out,
    output logic [AMP_W-1:0] cos_out,
    output logic             out_valid
);
    logic             commit;
    logic [ACC_W-1:0] act_ftw;
    logic [ACC_W-1:0] act_off;
    logic [ACC_W-1:0] acc_q;
    logic [PH_W-1:0]  phase_q;
    logic [AMP_W-1:0] sin_q;
    logic [AMP_W-1:0] cos_q;
    logic             run_en;
    logic             vld;
    nco_state_e       st;

    nco_regs #(.ACC_W(ACC_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (commit),
        .act_ftw (act_ftw),
        .act_off (act_off)
    );

    nco_ctrl #(.LAT(NCO_PIPE_LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .state     (st),
        .run_en    (run_en),
        .out_valid (vld)
    );

    nco_phase #(
        .ACC_W     (ACC_W),
        .PH_W      (PH_W),
        .LFSR_W    (LFSR_W),
        .LFSR_TAPS (LFSR_TAPS),
        .LFSR_SEED (LFSR_SEED)
    ) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .dither_en (dither_en),
        .act_ftw   (act_ftw),
        .act_off   (act_off),
        .acc_q     (acc_q),
        .phase_q   (phase_q)
    );

    nco_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_lut (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase_q),
        .sin_q (sin_q),
        .cos_q (cos_q)
    );

    assign sin_out   = vld ? sin_q : '0;
    assign cos_out   = vld ? cos_q : '0;
    assign out_valid = vld;
endmodule

// File: rtl/nco_dither_core_chk.sv
module nco_dither_core_chk
    import nco_pkg::*;
#(
    parameter int ACC_W = NCO_ACC_W,
    parameter int AMP_W = NCO_AMP_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input nco_state_e       state,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] act_ftw,
    input logic [ACC_W-1:0] act_off,
    input logic [AMP_W-1:0] sin_out,
    input logic [AMP_W-1:0] cos_out,
    input logic             out_valid
);
    localparam logic [ACC_W-1:0] FTW_LIM = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic [AMP_W-1:0] AMP_BAD = {1'b1, {(AMP_W-1){1'b0}}};

    logic is_commit;
    logic is_spare;
    assign is_commit = wr_en && (wr_addr == 2'd2);
    assign is_spare  = wr_en && (wr_addr == 2'd3);

    a_r2_ftw_limit: assert property (@(posedge clk) disable iff (!rst_n)
        act_ftw <= FTW_LIM);

    a_r3_hold_uncommitted: assert property (@(posedge clk) disable iff (!rst_n)
        !is_commit |=> $stable(act_ftw) && $stable(act_off));

    a_r4_phase_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> acc == $past(acc) + $past(act_ftw));

    a_r6_sin_range: assert property (@(posedge clk) disable iff (!rst_n)
        sin_out != AMP_BAD && cos_out != AMP_BAD);

    a_r8_fill_three: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(state) == ST_FILL && $past(state, 2) == ST_FILL
                             && $past(state, 3) == ST_FILL && $past(state, 4) == ST_IDLE);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !out_valid && acc == '0 && sin_out == '0);

    a_r9_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    a_r10_spare_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        is_spare |=> $stable(act_ftw) && $stable(act_off));
endmodule

bind nco_dither_core nco_dither_core_chk #(.ACC_W(ACC_W), .AMP_W(AMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .state     (st),
    .acc       (acc_q),
    .act_ftw   (act_ftw),
    .act_off   (act_off),
    .sin_out   (sin_out),
    .cos_out   (cos_out),
    .out_valid (out_valid)
);

// File: tb/sim_nco_dither_core.sv
`timescale 1ns/1ps
module sim_nco_dither_core;
    localparam real PI = 3.141592653589793;
    localparam int  NV = 7;
    // {tuning word, offset, cycles}
    localparam logic [95:0] VEC [NV] = '{
        {32'h0100_0000, 32'h0000_0000, 32'd300},
        {32'h1234_5678, 32'h4000_0000, 32'd200},
        {32'h7FFF_FFFF, 32'h8000_0000, 32'd100},
        {32'hFFFF_FFFF, 32'h2000_0000, 32'd50},
        {32'h0000_0001, 32'hC000_0000, 32'd50},
        {32'h0000_0000, 32'h1FFF_FFFF, 32'd20},
        {32'h8000_0000, 32'h0000_0000, 32'd20}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        dither_en = 1'b0;
    logic [13:0] sin_out;
    logic [13:0] cos_out;
    logic        out_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;
    string tag = "R1";

    nco_dither_core u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dither_en(dither_en),
        .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
    );

    always #10 clk = ~clk;

    // expected behaviour from the requirements
    logic [31:0] m_acc, m_ftw, m_off, m_sftw, m_soff, m_sum;
    logic [11:0] p1, p2, p3;
    bit          m_run;
    int          m_cnt;
    bit          m_vld;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_ftw = 0; m_off = 0; m_sftw = 0; m_soff = 0;
            p1 = 0; p2 = 0; p3 = 0; m_run = 0; m_cnt = 0;
        end else begin
            p3 = p2; p2 = p1;
            m_sum = m_acc + m_off;
            p1 = m_sum[31:20];
            if (m_run) begin
                m_acc = m_acc + m_ftw;
                if (m_cnt < 3) m_cnt++;
            end
            if (wr_en && wr_addr == 2'd2) begin
                if (!m_run) begin m_run = 1; m_cnt = 0; end
                m_ftw = m_sftw;
                m_off = m_soff;
            end
            if (wr_en && wr_addr == 2'd0) m_sftw = (wr_data > 32'h8000_0000) ? 32'h8000_0000 : wr_data;
            if (wr_en && wr_addr == 2'd1) m_soff = wr_data;
        end
        m_vld = m_run && (m_cnt >= 3);
    end

    function automatic int exp_amp(int p);
        real x;
        x = 8191.0 * $sin(2.0 * PI * (real'(p % 4096) + 0.5) / 4096.0);
        return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    endfunction

    function automatic bit near(int a, int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // running comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check(out_valid == m_vld, "R8", int'(out_valid), int'(m_vld));
            if (m_vld) begin
                check(near(int'($signed(sin_out)), exp_amp(int'(p3))), tag,
                      int'($signed(sin_out)), exp_amp(int'(p3)));
                check(near(int'($signed(cos_out)), exp_amp(int'(p3) + 1024)), tag,
                      int'($signed(cos_out)), exp_amp(int'(p3) + 1024));
            end else begin
                check(sin_out == 0 && cos_out == 0, "R9", int'(sin_out), 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
        end
    end

    initial begin
        int c0, c1, bad, s;
        repeat (4) @(negedge clk);
        check(out_valid == 0 && sin_out == 0 && cos_out == 0, "R9", int'(out_valid), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check(out_valid == 0 && sin_out == 0, "R9", int'(sin_out), 0);
        chk_on = 1'b1;

        // vector table: R1 R2 R4 R5 R6 through the model
        tag = "R1,R2,R4,R5,R6";
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, VEC[v][95:64]);
            wr(2'd1, VEC[v][63:32]);
            wr(2'd2, 32'h0);
            if (v == 0) begin
                check(out_valid == 0, "R8", int'(out_valid), 0);
                repeat (2) begin
                    @(negedge clk);
                    check(out_valid == 0, "R8", int'(out_valid), 0);
                end
                @(negedge clk);
                check(out_valid == 1, "R8", int'(out_valid), 1);
            end
            repeat (int'(VEC[v][31:0])) @(negedge clk);
        end

        // frozen phase tests
        do_reset();
        tag = "R3,R5,R10";
        wr(2'd0, 32'h0); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        check(near(int'($signed(sin_out)), 6), "R6", int'($signed(sin_out)), 6);
        check(near(int'($signed(cos_out)), 8191), "R6", int'($signed(cos_out)), 8191);
        wr(2'd1, 32'h4000_0000);
        repeat (6) @(negedge clk);
        check(near(int'($signed(sin_out)), 6), "R3", int'($signed(sin_out)), 6);
        wr(2'd3, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        check(near(int'($signed(sin_out)), 8191), "R5", int'($signed(sin_out)), 8191);
        check(near(int'($signed(cos_out)), -6), "R5", int'($signed(cos_out)), -6);
        wr(2'd3, 32'h1234_0000);
        wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        check(near(int'($signed(sin_out)), 8191), "R10", int'($signed(sin_out)), 8191);
        wr(2'd1, 32'h8000_0000);
        wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        check(near(int'($signed(sin_out)), -6), "R6", int'($signed(sin_out)), -6);

        // clamp: half-rate tone alternates sign
        wr(2'd0, 32'hFFFF_FFFF); wr(2'd1, 32'h0); wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        s = int'($signed(sin_out));
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            check(near(int'($signed(sin_out)), -s) && near(s < 0 ? -s : s, 6), "R2",
                  int'($signed(sin_out)), -s);
            s = int'($signed(sin_out));
        end

        // dither section
        chk_on = 1'b0;
        do_reset();
        dither_en = 1'b1;
        wr(2'd0, 32'h0); wr(2'd1, 32'h0008_0000); wr(2'd2, 32'h0);
        repeat (5) @(negedge clk);
        c0 = 0; c1 = 0; bad = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            s = int'($signed(sin_out));
            if (near(s, exp_amp(0)))      c0++;
            else if (near(s, exp_amp(1))) c1++;
            else                          bad++;
        end
        check(bad == 0, "R7", bad, 0);
        check(c0 > 0, "R7", c0, 1);
        check(c1 > 0, "R7", c1, 1);
        dither_en = 1'b0;
        repeat (5) @(negedge clk);
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!near(int'($signed(sin_out)), exp_amp(0))) bad++;
        end
        check(bad == 0, "R7", bad, 0);

        done = 1'b1;
        summary();
    end
endmodule